// File: doc/BRIEF.md
# Programmable Serial Receiver with Status Flags

This block recovers characters from an asynchronous serial line. A line enable pulse, `tick`, arrives at sixteen times the bit rate. The line rests high. A low level held for half a bit time marks the start of a character. After that, each bit is sampled once, near its centre. The block assembles 5 to 8 data bits, least significant bit first. It can then check a parity bit, and it checks one or two stop bits. The finished word moves into an output buffer register, and the data-ready and error flags update in the same cycle.

Word length, parity sense, parity inhibit and the number of stop bits come from static inputs, so they can be changed at run time. The output word is right-justified, and bits above the selected length read as zero. The consumer clears data ready with an active-low pulse. If a new word arrives while data ready is still set, the block reports an overrun. Two disable inputs drive the enable indications that go with the data and flag outputs. A master reset returns the receive sequencer and every flag to their idle state. It does not clear the output data register.

Top module: `serial_rx_unit`

## Requirements
- R1: While the line stays high, no word is received and `drdy` stays low.
- R2: A character is a low start bit, then data bits LSB first, then the optional parity bit, then the stop bits. Each bit lasts 16 ticks. `wl_sel` picks the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: `rx_data` holds the received word right-justified. Bits above the selected length are 0.
- R4: When parity is enabled, `par_even`=1 selects even parity and 0 selects odd parity, counted over the data bits plus the parity bit. `perr` goes high for a word whose parity does not match.
- R5: When `par_off`=1, no parity bit is expected, so the first stop bit follows the last data bit. In this mode `perr` is 0 after every word.
- R6: `ferr` goes high if a sampled stop bit is low. With `two_stop`=1, both stop bits are sampled and either one being low sets `ferr`.
- R7: `drdy` rises when a word enters the output register. A low level on `drdy_clr_n` clears it. If a word transfer and a clear fall in the same cycle, the transfer wins.
- R8: `oerr` goes high when a word is transferred while `drdy` is still set from the previous word.
- R9: A start bit is accepted only if the line is still low 8 ticks after the falling edge is detected. A shorter low pulse is ignored and the receiver returns to idle.
- R10: `mreset` clears `drdy`, `perr`, `ferr` and `oerr`, and `rx_data` keeps its value.
- R11: `rx_data_en` is the inverse of `out_dis`, and `flags_en` is the inverse of `flag_dis`.
- R12: All three error flags are rewritten on every word transfer, so a clean word clears flags that were set by earlier words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mreset | input | 1 | Synchronous master reset, active high |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| line_in | input | 1 | Asynchronous serial input, idle high |
| wl_sel | input | 2 | Data length select (00=5 through 11=8) |
| par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| par_off | input | 1 | 1 disables the parity bit and the parity check |
| two_stop | input | 1 | 1 expects two stop bits |
| drdy_clr_n | input | 1 | Active-low clear for data ready |
| out_dis | input | 1 | Data output disable |
| flag_dis | input | 1 | Status flag disable |
| rx_data | output | 8 | Received word, right-justified and zero-filled |
| rx_data_en | output | 1 | Data outputs enabled |
| drdy | output | 1 | Data ready |
| perr | output | 1 | Parity error |
| ferr | output | 1 | Framing error |
| oerr | output | 1 | Overrun error |
| flags_en | output | 1 | Status flag outputs enabled |

## Verification
Frames are sent at each of the four word lengths. Some data values carry set bits above the chosen length, which shows whether zero-filling works or stale high bits leak through. Parity is tried in even, odd and inhibited modes, each with correct and corrupted parity bits. This separates a wrong parity sense from a parity bit that is misplaced when parity is inhibited. Stop-bit faults are placed in the first and in the second stop position, a runt low pulse tests start validation, and back-to-back words with and without an intervening clear separate overrun from normal reception.

// File: rtl/rx_pkg.sv
`timescale 1ns/1ps
package rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  // number of data bits selected by the length code
  function automatic logic [3:0] word_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  // bits that are valid for the selected length
  function automatic logic [DATA_W-1:0] low_mask(input logic [1:0] sel);
    return 8'hFF >> (2'd3 - sel);
  endfunction

  // MSB-filled shift register to right-justified, zero-filled word
  function automatic logic [DATA_W-1:0] justify(input logic [DATA_W-1:0] sr,
                                                input logic [1:0] sel);
    return sr >> (2'd3 - sel);
  endfunction

  // 1 when data plus parity bit disagree with the selected sense
  function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                      input logic p, input logic even);
    return (^d) ^ p ^ ~even;
  endfunction
endpackage

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic mreset,
  input  logic line_in,
  output logic line_s
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (mreset) chain <= '1;
    else        chain <= {chain[STAGES-2:0], line_in};
  end

  assign line_s = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
`timescale 1ns/1ps
module rx_framer
  import rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              mreset,
  input  logic              tick,
  input  logic              line_s,
  input  logic [1:0]        wl_sel,
  input  logic              par_even,
  input  logic              par_off,
  input  logic              two_stop,
  output logic              xfer,
  output logic [DATA_W-1:0] xfer_data,
  output logic              xfer_perr,
  output logic              xfer_ferr
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] HALF_LAST = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [2:0]        bitn;
  logic [DATA_W-1:0] sr;
  logic              pbit;
  logic              stop_bad;

  // named internal events
  logic in_frame, sample_pt, start_eval, start_ok, start_reject, last_data;
  assign in_frame     = (state == ST_DATA) || (state == ST_PAR) ||
                        (state == ST_STOP1) || (state == ST_STOP2);
  assign sample_pt    = tick && in_frame && (cnt == FULL_LAST);
  assign start_eval   = tick && (state == ST_START) && (cnt == HALF_LAST);
  assign start_ok     = start_eval && !line_s;
  assign start_reject = start_eval && line_s;
  assign last_data    = ({1'b0, bitn} == word_bits(wl_sel) - 4'd1);

  always_ff @(posedge clk) begin
    if (mreset) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sr       <= '0;
      pbit     <= 1'b0;
      stop_bad <= 1'b0;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: if (!line_s) begin
          state <= ST_START;
          cnt   <= '0;
        end
        ST_START: begin
          if (cnt == HALF_LAST) begin
            cnt  <= '0;
            bitn <= '0;
            state <= line_s ? ST_IDLE : ST_DATA;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt != FULL_LAST) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            unique case (state)
              ST_DATA: begin
                sr <= {line_s, sr[DATA_W-1:1]};
                if (last_data) state <= par_off ? ST_STOP1 : ST_PAR;
                else           bitn  <= bitn + 1'b1;
              end
              ST_PAR: begin
                pbit  <= line_s;
                state <= ST_STOP1;
              end
              ST_STOP1: begin
                stop_bad <= !line_s;
                state    <= two_stop ? ST_STOP2 : ST_IDLE;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign xfer      = sample_pt && (((state == ST_STOP1) && !two_stop) ||
                                   (state == ST_STOP2));
  assign xfer_data = justify(sr, wl_sel);
  assign xfer_ferr = (state == ST_STOP2) ? (stop_bad || !line_s) : !line_s;
  assign xfer_perr = !par_off && parity_bad(xfer_data, pbit, par_even);

  // R9: a start that is high at its evaluation tick falls back to idle
  assert_runt_start_dropped_R9: assert property (@(posedge clk) disable iff (mreset)
    start_reject |=> (state == ST_IDLE));

  // R2: a confirmed start always leads into data reception
  assert_start_enters_data_R2: assert property (@(posedge clk) disable iff (mreset)
    start_ok |=> (state == ST_DATA) && (bitn == 3'd0));
endmodule

// File: rtl/rx_holdreg.sv
`timescale 1ns/1ps
module rx_holdreg
  import rx_pkg::*;
(
  input  logic              clk,
  input  logic              mreset,
  input  logic              xfer,
  input  logic [DATA_W-1:0] xfer_data,
  input  logic              xfer_perr,
  input  logic              xfer_ferr,
  input  logic              drdy_clr_n,
  input  logic [1:0]        wl_sel,
  input  logic              par_off,
  output logic [DATA_W-1:0] data_q,
  output logic              drdy,
  output logic              perr,
  output logic              ferr,
  output logic              oerr
);
  always_ff @(posedge clk) begin
    if (mreset) begin
      drdy <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
      oerr <= 1'b0;
    end else if (xfer) begin
      drdy <= 1'b1;
      perr <= xfer_perr;
      ferr <= xfer_ferr;
      oerr <= drdy;
    end else if (!drdy_clr_n) begin
      drdy <= 1'b0;
    end
  end

  // data register is deliberately outside master reset
  always_ff @(posedge clk) begin
    if (xfer) data_q <= xfer_data;
  end

  assert_drdy_on_xfer_R7: assert property (@(posedge clk) disable iff (mreset)
    xfer |=> drdy);

  assert_drdy_cleared_R7: assert property (@(posedge clk) disable iff (mreset)
    (!xfer && !drdy_clr_n) |=> !drdy);

  assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (mreset)
    (xfer && drdy) |=> oerr);

  assert_zero_fill_R3: assert property (@(posedge clk) disable iff (mreset)
    xfer |=> ((data_q & ~low_mask($past(wl_sel))) == '0));

  assert_perr_inhibited_R5: assert property (@(posedge clk) disable iff (mreset)
    (xfer && par_off) |=> !perr);

  assert_reset_flags_R10: assert property (@(posedge clk)
    mreset |=> (!drdy && !perr && !ferr && !oerr));
endmodule

// File: rtl/serial_rx_unit.sv
`timescale 1ns/1ps
module serial_rx_unit
  import rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       mreset,
  input  logic       tick,
  input  logic       line_in,
  input  logic [1:0] wl_sel,
  input  logic       par_even,
  input  logic       par_off,
  input  logic       two_stop,
  input  logic       drdy_clr_n,
  input  logic       out_dis,
  input  logic       flag_dis,
  output logic [7:0] rx_data,
  output logic       rx_data_en,
  output logic       drdy,
  output logic       perr,
  output logic       ferr,
  output logic       oerr,
  output logic       flags_en
);
  logic              line_s;
  logic              xfer;
  logic [DATA_W-1:0] xfer_data;
  logic              xfer_perr, xfer_ferr;

  rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .mreset(mreset), .line_in(line_in), .line_s(line_s)
  );

  rx_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .mreset(mreset), .tick(tick), .line_s(line_s),
    .wl_sel(wl_sel), .par_even(par_even), .par_off(par_off),
    .two_stop(two_stop), .xfer(xfer), .xfer_data(xfer_data),
    .xfer_perr(xfer_perr), .xfer_ferr(xfer_ferr)
  );

  rx_holdreg u_hold (
    .clk(clk), .mreset(mreset), .xfer(xfer), .xfer_data(xfer_data),
    .xfer_perr(xfer_perr), .xfer_ferr(xfer_ferr), .drdy_clr_n(drdy_clr_n),
    .wl_sel(wl_sel), .par_off(par_off), .data_q(rx_data), .drdy(drdy),
    .perr(perr), .ferr(ferr), .oerr(oerr)
  );

  assign rx_data_en = !out_dis;
  assign flags_en   = !flag_dis;

  // R11: enables follow the disable inputs combinationally
  always_comb begin
    assert_enables_R11: assert ((rx_data_en != out_dis) && (flags_en != flag_dis));
  end
endmodule

// File: tb/tb_serial_rx_unit.sv
`timescale 1ns/1ps
module tb_serial_rx_unit;
  logic       clk = 1'b0;
  logic       mreset = 1'b1;
  logic       tick = 1'b0;
  logic       line_in = 1'b1;
  logic [1:0] wl_sel = 2'd3;
  logic       par_even = 1'b1, par_off = 1'b0, two_stop = 1'b0;
  logic       drdy_clr_n = 1'b1, out_dis = 1'b0, flag_dis = 1'b0;
  logic [7:0] rx_data;
  logic       rx_data_en, drdy, perr, ferr, oerr, flags_en;

  int checks = 0;
  int fails  = 0;
  logic [1:0] tdiv = 2'd0;

  always #2.5 clk = ~clk;

  // one tick every 4 clocks, so one bit time is 64 clocks
  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  serial_rx_unit dut (
    .clk(clk), .mreset(mreset), .tick(tick), .line_in(line_in),
    .wl_sel(wl_sel), .par_even(par_even), .par_off(par_off),
    .two_stop(two_stop), .drdy_clr_n(drdy_clr_n), .out_dis(out_dis),
    .flag_dis(flag_dis), .rx_data(rx_data), .rx_data_en(rx_data_en),
    .drdy(drdy), .perr(perr), .ferr(ferr), .oerr(oerr), .flags_en(flags_en)
  );

  typedef struct packed {
    logic [1:0] wl;
    logic       even;
    logic       off;
    logic       two;
    logic [7:0] data;
    logic       bad_par;
    logic [1:0] bad_stop;   // [0] first stop low, [1] second stop low
    logic [7:0] exp_data;
    logic       exp_perr;
    logic       exp_ferr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd3, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b0, 2'b00, 8'hA5, 1'b0, 1'b0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 2'b00, 8'h1F, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b0, 2'b00, 8'h3C, 1'b0, 1'b0},
    '{2'd2, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 2'b00, 8'h55, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 8'h81, 1'b1, 2'b00, 8'h81, 1'b1, 1'b0},
    '{2'd3, 1'b0, 1'b1, 1'b0, 8'h7E, 1'b1, 2'b00, 8'h7E, 1'b0, 1'b0},
    '{2'd0, 1'b1, 1'b0, 1'b0, 8'h0A, 1'b0, 2'b01, 8'h0A, 1'b0, 1'b1},
    '{2'd2, 1'b1, 1'b0, 1'b1, 8'h13, 1'b0, 2'b10, 8'h13, 1'b0, 1'b1},
    '{2'd1, 1'b0, 1'b0, 1'b0, 8'hC0, 1'b1, 2'b00, 8'h00, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_time(input logic b);
    line_in = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] wl, input logic even, input logic off,
                      input logic two, input logic [7:0] d, input logic bad_par,
                      input logic [1:0] bad_stop);
    int n = 5 + int'(wl);
    logic par = 1'b0;
    wl_sel = wl; par_even = even; par_off = off; two_stop = two;
    bit_time(1'b0);
    for (int i = 0; i < n; i++) begin
      bit_time(d[i]);
      par = par ^ d[i];
    end
    // even sense: parity bit equals XOR of data; odd sense: its inverse
    if (!off) bit_time((even ? par : ~par) ^ bad_par);
    bit_time(~bad_stop[0]);
    if (two) bit_time(~bad_stop[1]);
    bit_time(1'b1);
    repeat (128) @(negedge clk);
  endtask

  task automatic clear_drdy();
    @(negedge clk) drdy_clr_n = 1'b0;
    @(negedge clk) drdy_clr_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    mreset = 1'b0;
    @(negedge clk);
    // reset state: R10 flags low, R11 enables active
    chk("R10 drdy after reset", {7'd0, drdy}, 8'd0);
    chk("R10 perr after reset", {7'd0, perr}, 8'd0);
    chk("R10 ferr after reset", {7'd0, ferr}, 8'd0);
    chk("R10 oerr after reset", {7'd0, oerr}, 8'd0);
    chk("R11 enables after reset", {6'd0, rx_data_en, flags_en}, 8'd3);

    // R1: idle line yields nothing
    repeat (600) @(negedge clk);
    chk("R1 idle drdy", {7'd0, drdy}, 8'd0);

    // R11: disable inputs
    out_dis = 1'b1; flag_dis = 1'b0; @(negedge clk);
    chk("R11 out_dis", {6'd0, rx_data_en, flags_en}, 8'd1);
    out_dis = 1'b0; flag_dis = 1'b1; @(negedge clk);
    chk("R11 flag_dis", {6'd0, rx_data_en, flags_en}, 8'd2);
    flag_dis = 1'b0;

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      clear_drdy();
      send(VEC[v].wl, VEC[v].even, VEC[v].off, VEC[v].two, VEC[v].data,
           VEC[v].bad_par, VEC[v].bad_stop);
      chk($sformatf("R7 drdy vec%0d", v), {7'd0, drdy}, 8'd1);
      chk($sformatf("R2/R3 data vec%0d", v), rx_data, VEC[v].exp_data);
      chk($sformatf("R4/R5 perr vec%0d", v), {7'd0, perr}, {7'd0, VEC[v].exp_perr});
      chk($sformatf("R6 ferr vec%0d", v), {7'd0, ferr}, {7'd0, VEC[v].exp_ferr});
      chk($sformatf("R8 no overrun vec%0d", v), {7'd0, oerr}, 8'd0);
    end

    // R7: clear works
    clear_drdy();
    @(negedge clk);
    chk("R7 drdy cleared", {7'd0, drdy}, 8'd0);

    // R9: runt low pulse of 4 ticks is ignored
    line_in = 1'b0;
    repeat (16) @(negedge clk);
    line_in = 1'b1;
    repeat (400) @(negedge clk);
    chk("R9 runt ignored", {7'd0, drdy}, 8'd0);
    send(2'd3, 1'b1, 1'b0, 1'b0, 8'h69, 1'b0, 2'b00);
    chk("R9 recovery data", rx_data, 8'h69);

    // R8: second word without clear
    send(2'd3, 1'b1, 1'b0, 1'b0, 8'h5A, 1'b0, 2'b00);
    chk("R8 overrun set", {7'd0, oerr}, 8'd1);
    chk("R8 newest data kept", rx_data, 8'h5A);

    // R12: flags rewritten by a clean word
    send(2'd3, 1'b1, 1'b0, 1'b0, 8'h33, 1'b1, 2'b01);
    clear_drdy();
    send(2'd3, 1'b1, 1'b0, 1'b0, 8'h44, 1'b0, 2'b00);
    chk("R12 oerr rewritten", {7'd0, oerr}, 8'd0);
    chk("R12 perr rewritten", {7'd0, perr}, 8'd0);
    chk("R12 ferr rewritten", {7'd0, ferr}, 8'd0);

    // R10: master reset clears flags, keeps data
    send(2'd3, 1'b1, 1'b0, 1'b0, 8'hC3, 1'b1, 2'b00);
    chk("R10 perr before reset", {7'd0, perr}, 8'd1);
    @(negedge clk) mreset = 1'b1;
    @(negedge clk);
    @(negedge clk) mreset = 1'b0;
    @(negedge clk);
    chk("R10 drdy cleared", {7'd0, drdy}, 8'd0);
    chk("R10 perr cleared", {7'd0, perr}, 8'd0);
    chk("R10 oerr cleared", {7'd0, oerr}, 8'd0);
    chk("R10 data kept", rx_data, 8'hC3);

    finish_run();
  end
endmodule